// File: doc/BRIEF.md
# Switch Table Indirect Access Port

This block gives a host processor access to two small lookup tables inside a packet switch. One table holds 16 VLAN entries and the other holds 8 static MAC entries. The host cannot address the entries directly. It reaches them through a window of three 32-bit registers on a plain register bus: a command register, a high data register and a low data register.

A write to a table takes two steps. The host first loads the data registers, then writes a command that names the direction, the table and the entry index. The table is updated one clock after the command is accepted, and the update always uses the data registers as they stood before that edge.

A read also starts with a command. One clock after the command, the selected entry appears in the data registers, where ordinary bus reads can collect it. Commands that name the dynamic table or the statistics counters have no storage behind them in this block, so they do nothing.

Top module: `swtbl_access`

## Requirements
- R1: After reset the command register and both data registers read zero, and every table entry is invalid, so any table read returns zeros.
- R2: Bus word address 0 is the command register (bits 12:0 read back, upper bits zero), address 1 is the high data register, address 2 is the low data register, and address 3 reads zero. The data registers keep their value unless the bus writes them or a table read loads them.
- R3: Command fields: bit 12 gives the direction (1 = read, 0 = write). Bits 11:10 select the table (0 = static MAC, 1 = VLAN, 2 = dynamic, 3 = counters). Bits 9:0 hold the entry index. Each command causes at most one table action.
- R4: A write command accepted at clock edge k stores the data registers into the entry at edge k+1. A VLAN entry takes low bits 21:0: valid at bit 21, 5-port membership at 20:16, filter ID at 15:12, VLAN ID at 11:0. A static MAC entry takes high bits 27:0 and all 32 low bits. In the high word, filter ID is at 27:24, use-filter-ID at 23, spanning-tree override at 22, valid at 21, forwarding mask at 20:16, and MAC bytes 5 and 4 at 15:0. The low word holds MAC bytes 3 to 0.
- R5: A read command accepted at edge k loads the entry at edge k+1. A VLAN read replaces the low register with the entry (bits 31:22 zero) and leaves the high register unchanged. A static MAC read replaces both registers, with high bits 31:28 zero.
- R6: Reading an entry whose valid bit is clear (VLAN low bit 21, static MAC high bit 21) loads zeros in place of the entry.
- R7: A command selecting table 2 or 3 changes neither table nor either data register.
- R8: An index at or beyond the selected table's depth (16 for VLAN, 8 for static MAC) makes a write change no entry, and makes a read load zeros.
- R9: If the bus writes a data register at the same edge that a read loads it, the bus value wins. A write command commits the data values held before that edge, even when the bus writes a data register at the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register word address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational on busAddr |

## Verification
Two actions can land on the same clock edge: a command's table action, which runs one edge after the command is accepted, and a fresh bus write to a data register. The bench provokes this by writing a data register in the very next bus cycle after a read command, and after a write command. It checks that the bus value replaces the loaded field while the other register still receives its part of the entry. It also reads the entry back later to confirm that a write commit used the data held before the colliding bus write.

// File: rtl/swtbl_pkg.sv
package swtbl_pkg;
  localparam int DATA_W   = 32;
  localparam int CMD_W    = 13;
  localparam int IDX_W    = 10;
  localparam int VLAN_EW  = 22;   // VLAN entry bits kept from the low word
  localparam int SMAC_HW  = 28;   // static MAC bits kept from the high word
  localparam int VALID_BIT = 21;  // valid flag position in both entry formats

  localparam logic [1:0] ADDR_CMD = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_LO  = 2'd2;

  typedef enum logic [1:0] {
    TBL_SMAC = 2'd0,
    TBL_VLAN = 2'd1,
    TBL_DYN  = 2'd2,
    TBL_CNT  = 2'd3
  } tblSel_e;

  // strobes from control to datapath, one clock after the command write
  typedef struct packed {
    logic             vlanWr;
    logic             vlanRd;
    logic             smacWr;
    logic             smacRd;
    logic             hit;     // index within the selected table
    logic [IDX_W-1:0] idx;
  } tblStrobe_t;
endpackage

// File: rtl/swtbl_ctrl.sv
module swtbl_ctrl
  import swtbl_pkg::*;
#(
  parameter int VLAN_DEPTH = 16,
  parameter int SMAC_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [CMD_W-1:0]  cmdReg,
  output tblStrobe_t        strb
);
  localparam logic [IDX_W:0] VLAN_LIM = (IDX_W+1)'(VLAN_DEPTH);
  localparam logic [IDX_W:0] SMAC_LIM = (IDX_W+1)'(SMAC_DEPTH);

  logic             isCmd;
  logic             dirRd;
  tblSel_e          tblSel;
  logic [IDX_W-1:0] cmdIdx;
  logic             vHit;
  logic             sHit;
  tblStrobe_t       strbNxt;

  always_comb begin
    isCmd  = busWr && (busAddr == ADDR_CMD);
    dirRd  = busWdata[12];
    tblSel = tblSel_e'(busWdata[11:10]);
    cmdIdx = busWdata[IDX_W-1:0];
    vHit   = {1'b0, cmdIdx} < VLAN_LIM;
    sHit   = {1'b0, cmdIdx} < SMAC_LIM;
    strbNxt = '0;
    if (isCmd) begin
      unique case (tblSel)
        TBL_VLAN: begin
          strbNxt.idx    = cmdIdx;
          strbNxt.hit    = vHit;
          strbNxt.vlanRd = dirRd;
          strbNxt.vlanWr = !dirRd && vHit;
        end
        TBL_SMAC: begin
          strbNxt.idx    = cmdIdx;
          strbNxt.hit    = sHit;
          strbNxt.smacRd = dirRd;
          strbNxt.smacWr = !dirRd && sHit;
        end
        default: strbNxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      strb   <= '0;
    end else begin
      if (isCmd) cmdReg <= busWdata[CMD_W-1:0];
      strb <= strbNxt;
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.vlanWr, strb.vlanRd, strb.smacWr, strb.smacRd})); // R3

  AST_OTHER_TABLE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_CMD && busWdata[11])
    |=> !(strb.vlanWr || strb.vlanRd || strb.smacWr || strb.smacRd)); // R7

  AST_RANGE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_CMD && !busWdata[12] && busWdata[11:10] == 2'd1
     && {1'b0, busWdata[IDX_W-1:0]} >= VLAN_LIM) |=> !strb.vlanWr); // R8
endmodule

// File: rtl/swtbl_dpath.sv
module swtbl_dpath
  import swtbl_pkg::*;
#(
  parameter int VLAN_DEPTH = 16,
  parameter int SMAC_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  tblStrobe_t        strb,
  output logic [DATA_W-1:0] dataHi,
  output logic [DATA_W-1:0] dataLo
);
  localparam int VLAN_IW = $clog2(VLAN_DEPTH);
  localparam int SMAC_IW = $clog2(SMAC_DEPTH);

  logic [VLAN_EW-1:0] vlanMem   [VLAN_DEPTH];
  logic [SMAC_HW-1:0] smacHiMem [SMAC_DEPTH];
  logic [DATA_W-1:0]  smacLoMem [SMAC_DEPTH];

  logic [VLAN_IW-1:0] vIdx;
  logic [SMAC_IW-1:0] sIdx;
  assign vIdx = strb.idx[VLAN_IW-1:0];
  assign sIdx = strb.idx[SMAC_IW-1:0];

  for (genvar g = 0; g < VLAN_DEPTH; g++) begin : gVlan
    logic [VLAN_EW-1:0] ent;
    always_ff @(posedge clk) begin
      if (!rstN) ent <= '0;
      else if (strb.vlanWr && vIdx == VLAN_IW'(g)) ent <= dataLo[VLAN_EW-1:0];
    end
    assign vlanMem[g] = ent;
  end

  for (genvar g = 0; g < SMAC_DEPTH; g++) begin : gSmac
    logic [SMAC_HW-1:0] entHi;
    logic [DATA_W-1:0]  entLo;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entHi <= '0;
        entLo <= '0;
      end else if (strb.smacWr && sIdx == SMAC_IW'(g)) begin
        entHi <= dataHi[SMAC_HW-1:0];
        entLo <= dataLo;
      end
    end
    assign smacHiMem[g] = entHi;
    assign smacLoMem[g] = entLo;
  end

  logic [DATA_W-1:0] vlanRdWord;
  logic [DATA_W-1:0] smacRdHi;
  logic [DATA_W-1:0] smacRdLo;
  logic              vValid;
  logic              sValid;

  always_comb begin
    vValid     = strb.hit && vlanMem[vIdx][VALID_BIT];
    sValid     = strb.hit && smacHiMem[sIdx][VALID_BIT];
    vlanRdWord = vValid ? {{(DATA_W-VLAN_EW){1'b0}}, vlanMem[vIdx]} : '0;
    smacRdHi   = sValid ? {{(DATA_W-SMAC_HW){1'b0}}, smacHiMem[sIdx]} : '0;
    smacRdLo   = sValid ? smacLoMem[sIdx] : '0;
  end

  logic hiBusWr;
  logic loBusWr;
  assign hiBusWr = busWr && (busAddr == ADDR_HI);
  assign loBusWr = busWr && (busAddr == ADDR_LO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataHi <= '0;
      dataLo <= '0;
    end else begin
      if (hiBusWr)          dataHi <= busWdata;
      else if (strb.smacRd) dataHi <= smacRdHi;
      if (loBusWr)          dataLo <= busWdata;
      else if (strb.smacRd) dataLo <= smacRdLo;
      else if (strb.vlanRd) dataLo <= vlanRdWord;
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr && !strb.vlanRd && !strb.smacRd)
    |=> ($stable(dataHi) && $stable(dataLo))); // R2

  AST_VLAN_READ_KEEPS_HI: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vlanRd && !hiBusWr) |=> $stable(dataHi)); // R5

  AST_SMAC_READ_ZERO_OR_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (strb.smacRd && !busWr)
    |=> ((dataHi == '0 && dataLo == '0) || dataHi[VALID_BIT])); // R6

  AST_BUS_WINS_LO: assert property (@(posedge clk) disable iff (!rstN)
    loBusWr |=> (dataLo == $past(busWdata))); // R9
endmodule

// File: rtl/swtbl_access.sv
module swtbl_access
  import swtbl_pkg::*;
#(
  parameter int VLAN_DEPTH = 16,
  parameter int SMAC_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);
  logic [CMD_W-1:0]  cmdReg;
  logic [DATA_W-1:0] dataHi;
  logic [DATA_W-1:0] dataLo;
  tblStrobe_t        strb;

  swtbl_ctrl #(.VLAN_DEPTH(VLAN_DEPTH), .SMAC_DEPTH(SMAC_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .cmdReg(cmdReg), .strb(strb)
  );

  swtbl_dpath #(.VLAN_DEPTH(VLAN_DEPTH), .SMAC_DEPTH(SMAC_DEPTH)) uDpath (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .strb(strb), .dataHi(dataHi), .dataLo(dataLo)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_CMD: busRdata = {{(DATA_W-CMD_W){1'b0}}, cmdReg};
      ADDR_HI:  busRdata = dataHi;
      ADDR_LO:  busRdata = dataLo;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: tb/tb_swtbl_access.sv
`timescale 1ns/1ps
module tb_swtbl_access;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  swtbl_access dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [12:0] mCmd;
  logic [31:0] mHi, mLo;
  logic [21:0] vlanM [16];
  logic [59:0] smacM [8];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
  endtask

  function automatic void modelExec(input logic [12:0] c);
    logic [9:0] i;
    i = c[9:0];
    case (c[11:10])
      2'd1: if (c[12]) mLo = (i < 16 && vlanM[i[3:0]][21]) ? {10'b0, vlanM[i[3:0]]} : 32'h0;
            else if (i < 16) vlanM[i[3:0]] = mLo[21:0];
      2'd0: if (c[12]) begin
              if (i < 8 && smacM[i[2:0]][53]) begin
                mHi = {4'b0, smacM[i[2:0]][59:32]};
                mLo = smacM[i[2:0]][31:0];
              end else begin
                mHi = 0; mLo = 0;
              end
            end else if (i < 8) smacM[i[2:0]] = {mHi[27:0], mLo};
      default: ;
    endcase
  endfunction

  task automatic setReg(input logic [1:0] a, input logic [31:0] d);
    wr(a, d);
    if (a == 2'd1) mHi = d;
    else if (a == 2'd2) mLo = d;
    else if (a == 2'd0) mCmd = d[12:0];
  endtask

  task automatic doCmd(input logic [12:0] c);
    wr(2'd0, {19'b0, c});
    mCmd = c;
    idle();
    modelExec(c);
  endtask

  // command then an immediate data write that lands on the action edge
  task automatic doCmdColl(input logic [12:0] c, input logic [1:0] a, input logic [31:0] d);
    wr(2'd0, {19'b0, c});
    mCmd = c;
    wr(a, d);
    modelExec(c);
    if (a == 2'd1) mHi = d; else mLo = d;
  endtask

  task automatic checkRegs(input string req);
    logic [31:0] v;
    peek(2'd1, v); chk({req, " hi"}, v, mHi);
    peek(2'd2, v); chk({req, " lo"}, v, mLo);
  endtask

  function automatic logic [12:0] mk(input bit rd, input logic [1:0] t, input int idx);
    return {rd, t, 10'(idx)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1234_abcd));
    mCmd = 0; mHi = 0; mLo = 0;
    for (int i = 0; i < 16; i++) vlanM[i] = 0;
    for (int i = 0; i < 8; i++) smacM[i] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    peek(2'd0, v); chk("R1 cmd", v, 0);
    peek(2'd1, v); chk("R1 hi", v, 0);
    peek(2'd2, v); chk("R1 lo", v, 0);
    setReg(2'd2, 32'hFFFF_FFFF);
    doCmd(mk(1, 2'd1, 5));
    peek(2'd2, v); chk("R1 vlan empty", v, 32'h0);

    // R2 register window
    setReg(2'd1, 32'hA5A5_0F0F);
    setReg(2'd2, 32'h1234_5678);
    peek(2'd1, v); chk("R2 hi rb", v, 32'hA5A5_0F0F);
    peek(2'd2, v); chk("R2 lo rb", v, 32'h1234_5678);
    peek(2'd3, v); chk("R2 addr3", v, 0);
    doCmd(mk(1, 2'd2, 9));
    peek(2'd0, v); chk("R2 cmd rb", v, 32'h0000_1809);

    // R4 R5 VLAN write then read back
    setReg(2'd2, 32'hFFE0_0000 | (1 << 21) | (5'h15 << 16) | (4'h9 << 12) | 12'h3C7);
    doCmd(mk(0, 2'd1, 15));
    setReg(2'd2, 32'h0);
    setReg(2'd1, 32'hDEAD_BEEF);
    doCmd(mk(1, 2'd1, 15));
    peek(2'd2, v); chk("R5 vlan lo", v, 32'h0035_93C7);
    peek(2'd1, v); chk("R5 vlan keeps hi", v, 32'hDEAD_BEEF);

    // R4 R5 static MAC write then read back
    setReg(2'd1, 32'hF000_0000 | (4'hB << 24) | (1 << 23) | (1 << 21) | (5'h0A << 16) | 16'h6655);
    setReg(2'd2, 32'h4433_2211);
    doCmd(mk(0, 2'd0, 7));
    setReg(2'd1, 0); setReg(2'd2, 0);
    doCmd(mk(1, 2'd0, 7));
    peek(2'd1, v); chk("R5 smac hi", v, 32'h0BAA_6655);
    peek(2'd2, v); chk("R5 smac lo", v, 32'h4433_2211);

    // R6 invalid entries read as zero
    setReg(2'd2, 32'h001F_FFFF);
    doCmd(mk(0, 2'd1, 2));
    doCmd(mk(1, 2'd1, 2));
    peek(2'd2, v); chk("R6 vlan invalid", v, 0);
    setReg(2'd1, 32'h00DF_FFFF); setReg(2'd2, 32'hFFFF_FFFF);
    doCmd(mk(0, 2'd0, 3));
    doCmd(mk(1, 2'd0, 3));
    checkRegs("R6 smac invalid");

    // R7 dynamic and counter commands ignored
    setReg(2'd1, 32'h0123_4567); setReg(2'd2, 32'h89AB_CDEF);
    doCmd(mk(0, 2'd2, 15));
    doCmd(mk(1, 2'd3, 7));
    checkRegs("R7 regs unchanged");
    doCmd(mk(1, 2'd1, 15));
    peek(2'd2, v); chk("R7 vlan untouched", v, 32'h0035_93C7);

    // R8 out of range index
    setReg(2'd2, 32'h003F_FFFF);
    doCmd(mk(0, 2'd1, 16));
    doCmd(mk(1, 2'd1, 0));
    peek(2'd2, v); chk("R8 no alias write", v, 0);
    setReg(2'd1, 32'h1111_1111); setReg(2'd2, 32'h2222_2222);
    doCmd(mk(1, 2'd0, 8));
    checkRegs("R8 smac read beyond depth");
    peek(2'd1, v); chk("R8 zero hi", v, 0);
    setReg(2'd2, 32'h5555_5555);
    doCmd(mk(1, 2'd1, 1023));
    peek(2'd2, v); chk("R8 vlan idx 1023", v, 0);

    // R9 collisions on the action edge
    doCmdColl(mk(1, 2'd1, 15), 2'd2, 32'hCAFE_0001);
    peek(2'd2, v); chk("R9 bus beats vlan load", v, 32'hCAFE_0001);
    doCmdColl(mk(1, 2'd0, 7), 2'd1, 32'hCAFE_0002);
    peek(2'd1, v); chk("R9 bus beats smac hi", v, 32'hCAFE_0002);
    peek(2'd2, v); chk("R9 smac lo still loads", v, 32'h4433_2211);
    setReg(2'd2, 32'h0020_0ABC);
    doCmdColl(mk(0, 2'd1, 4), 2'd2, 32'h0000_0000);
    doCmd(mk(1, 2'd1, 4));
    peek(2'd2, v); chk("R9 commit uses old data", v, 32'h0020_0ABC);

    // R3 random mix against the model
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom % 4;
      if (op == 0) setReg(2'd1, $urandom | (($urandom % 2) << 21));
      else if (op == 1) setReg(2'd2, $urandom | (($urandom % 2) << 21));
      else begin
        logic [12:0] c;
        c = mk($urandom % 2, 2'($urandom % 4),
               ($urandom % 4 == 0) ? int'($urandom % 1024) : int'($urandom % 20));
        if ($urandom % 6 == 0) doCmdColl(c, 2'($urandom % 2 + 1), $urandom);
        else doCmd(c);
        peek(2'd0, v); chk("R3 cmd", v, {19'b0, mCmd});
      end
      checkRegs("R3 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule